// File: doc/BRIEF.md
# TPM FIFO Command/Response Sequencer

The sequencer carries one TPM command to a device and brings back its response. It uses only two device registers, the status register and the data FIFO. Every device access goes out through an external register transaction master, which handles the serial framing and the wait states. The sequencer reads the command from a local byte buffer and checks the length field in the header. It then asks the device to prepare, writes the command in chunks that the device allows, and starts execution. It polls for the result at a fixed interval until a timeout. It reads the response into a local buffer, checks the data-available flag on each side of the final byte, and returns the device to its idle state.

The caller loads the command buffer and gives the command length and the capacity of the response buffer. It then pulses `start_i` and waits for `done_o`. On success the response length is reported. Any failed check ends the sequence and raises `err_o`.

Each transaction is held on `txn_req_o` until the master pulses `txn_done_i`. Write bytes are shown on `txn_wdata_o` and consumed by `txn_wtake_i`. Read bytes come back with `txn_rvalid_i`. Multi-byte status values are carried least significant byte first.

Top module: `tpm_fifo_seq`

## Requirements
- R1: The big-endian 32-bit length at command bytes 2..5 must equal `cmd_len_i`, and `cmd_len_i` must be at least 6. If either check fails, the sequence ends with `err_o` set and no bus transaction at all. `done_o` rises 5 cycles after the edge that samples `start_i`.
- R2: The first transaction is a 4-byte write to the status address whose low byte is 0x40 (command-ready, bit 6).
- R3: Before each FIFO chunk, the status register is read and the burst count is taken from status bits 23:8. While the burst count is zero, the status read is repeated and no FIFO access is made.
- R4: Each FIFO write chunk is min(remaining command bytes, burst count, 64). The bytes are sent in buffer order, so the device receives the whole command unchanged.
- R5: Right after the last command byte, a 4-byte status write with low byte 0x20 (go, bit 5) is issued.
- R6: The status register is then polled, with at least POLL_CYC idle cycles between reads, until bits 7 (valid) and 4 (data-available) are both set. If TIMEOUT_CYC cycles elapse first, the sequence ends with an error.
- R7: The response header is read as one 6-byte FIFO transaction. Its big-endian length at bytes 2..5 is an error if it is above `rsp_max_i` or below 7, and nothing follows the header read in that case.
- R8: The response bytes from 6 up to length-2 are read in chunks sized as in R3/R4. A status read follows, and it must show bits 7 and 4 both set or the sequence ends with an error.
- R9: The final byte is read as a 1-byte FIFO transaction. The following status read must show bit 7 set and bit 4 clear, otherwise the sequence ends with an error.
- R10: On success, a last 4-byte status write of 0x40 is made. The response buffer then holds every response byte at addresses 0..length-1, `rsp_len_o` equals the length, and `err_o` is low.
- R11: `done_o` is a one-cycle pulse. `err_o` and `rsp_len_o` are valid from that pulse until the next start, and `rsp_len_o` is 0 after an error. All outputs are idle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a command, sampled when idle |
| cmd_len_i | input | BUF_AW+1 | command length in bytes |
| cmd_addr_o | output | BUF_AW | command buffer read address |
| cmd_data_i | input | 8 | command buffer byte at `cmd_addr_o` (combinational) |
| rsp_max_i | input | BUF_AW+1 | response buffer capacity |
| rsp_we_o | output | 1 | response buffer write strobe |
| rsp_addr_o | output | BUF_AW | response buffer write address |
| rsp_data_o | output | 8 | response buffer write data |
| txn_req_o | output | 1 | transaction request, held until done |
| txn_write_o | output | 1 | 1 = register write, 0 = read |
| txn_addr_o | output | ADDR_W | register address |
| txn_len_o | output | $clog2(MAX_CHUNK+1) | transaction byte count |
| txn_wdata_o | output | 8 | current write byte |
| txn_wtake_i | input | 1 | master consumed the write byte |
| txn_rvalid_i | input | 1 | read byte valid |
| txn_rdata_i | input | 8 | read byte |
| txn_done_i | input | 1 | transaction complete |
| done_o | output | 1 | sequence finished (pulse) |
| err_o | output | 1 | sequence failed |
| rsp_len_o | output | BUF_AW+1 | response length, 0 on error |

## Verification
The length check has a fixed latency. The bench measures that `done_o` appears exactly five falling edges after the start is released, and that it is not present earlier. Everything after that depends on the device model's pacing. So the bench logs each transaction at the falling edge on which it first sees `txn_req_o`, answers one byte per cycle, and judges ordering, lengths and bytes from that log once `done_o` has been seen. The one-cycle width of `done_o` is sampled on the falling edge right after the pulse. The poll spacing is measured from the cycle stamps of consecutive status reads.

// File: rtl/tpm_fifo_seq_pkg.sv
package tpm_fifo_seq_pkg;
  typedef enum logic [4:0] {
    S_IDLE, S_LEN, S_CMP, S_RDY, S_BC, S_WR, S_GO, S_WAIT, S_POLL,
    S_HDR, S_HCHK, S_BBC, S_BODY, S_MID, S_LAST, S_FIN, S_REL
  } seq_state_e;

  localparam logic [7:0] STS_CMD_READY = 8'h40;
  localparam logic [7:0] STS_GO        = 8'h20;
  localparam logic [7:0] STS_VALID     = 8'h80;
  localparam logic [7:0] AVAIL_MASK    = 8'h90;  // valid | data-available
  localparam int unsigned HDR_BYTES    = 6;
endpackage

// File: rtl/tpm_fifo_seq_chunk.sv
module tpm_fifo_seq_chunk #(
  parameter int RW        = 13,
  parameter int MAX_CHUNK = 64,
  parameter int LW        = 7
) (
  input  logic [RW-1:0] remain_i,
  input  logic [15:0]   burst_i,
  output logic [LW-1:0] len_o
);
  logic [31:0] r, b, m;
  always_comb begin
    r = 32'(remain_i);
    b = 32'(burst_i);
    m = (r < b) ? r : b;
    if (m > 32'(MAX_CHUNK)) m = 32'(MAX_CHUNK);
    len_o = LW'(m);
  end
endmodule

// File: rtl/tpm_fifo_seq_timer.sv
module tpm_fifo_seq_timer #(
  parameter int unsigned      POLL_CYC    = 250000,
  parameter longint unsigned  TIMEOUT_CYC = 64'd30000000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic wait_i,
  input  logic active_i,
  output logic poll_due_o,
  output logic expired_o
);
  localparam int PW = $clog2(POLL_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [PW-1:0] wait_q;
  logic [TW-1:0] total_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q  <= '0;
      total_q <= '0;
    end else begin
      wait_q <= wait_i ? wait_q + PW'(1) : '0;
      if (arm_i) total_q <= '0;
      else if (active_i && !expired_o) total_q <= total_q + TW'(1);
    end
  end

  assign poll_due_o = wait_i && (wait_q >= PW'(POLL_CYC - 1));
  assign expired_o  = (total_q >= TW'(TIMEOUT_CYC));

  p_expire_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_o) |-> $past(active_i));
endmodule

// File: rtl/tpm_fifo_seq.sv
module tpm_fifo_seq
  import tpm_fifo_seq_pkg::*;
#(
  parameter int              ADDR_W      = 24,
  parameter logic [23:0]     STS_ADDR    = 24'h000018,
  parameter logic [23:0]     FIFO_ADDR   = 24'h000024,
  parameter int              BUF_AW      = 12,
  parameter int              MAX_CHUNK   = 64,
  parameter int unsigned     POLL_CYC    = 250000,
  parameter longint unsigned TIMEOUT_CYC = 64'd30000000000,
  localparam int             BL          = BUF_AW + 1,
  localparam int             LW          = $clog2(MAX_CHUNK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BL-1:0]     cmd_len_i,
  output logic [BUF_AW-1:0] cmd_addr_o,
  input  logic [7:0]        cmd_data_i,
  input  logic [BL-1:0]     rsp_max_i,
  output logic              rsp_we_o,
  output logic [BUF_AW-1:0] rsp_addr_o,
  output logic [7:0]        rsp_data_o,
  output logic              txn_req_o,
  output logic              txn_write_o,
  output logic [ADDR_W-1:0] txn_addr_o,
  output logic [LW-1:0]     txn_len_o,
  output logic [7:0]        txn_wdata_o,
  input  logic              txn_wtake_i,
  input  logic              txn_rvalid_i,
  input  logic [7:0]        txn_rdata_i,
  input  logic              txn_done_i,
  output logic              done_o,
  output logic              err_o,
  output logic [BL-1:0]     rsp_len_o
);
  seq_state_e state_q, state_d;
  logic [LW-1:0] idx_q, chunk_q, chunk_len;
  logic [23:0]   sts_q;
  logic [31:0]   field_q;
  logic [BL-1:0] cmd_len_q, rsp_max_q, cmd_ptr_q, rsp_ptr_q, rsp_len_q, rsp_out_q, remain;
  logic [15:0]   burst_q, burst_now;
  logic          done_q, err_q, fin, fin_err;
  logic          len_ok, avail_both, fifo_rd, sts_rd, poll_due, expired;

  assign burst_now  = sts_q[23:8];
  assign avail_both = (sts_q[7:0] & AVAIL_MASK) == AVAIL_MASK;
  assign len_ok     = (field_q == 32'(cmd_len_q)) && (cmd_len_q >= BL'(HDR_BYTES));

  // bus side
  assign txn_req_o   = !(state_q inside {S_IDLE, S_LEN, S_CMP, S_WAIT, S_HCHK});
  assign txn_write_o = state_q inside {S_RDY, S_WR, S_GO, S_REL};
  assign fifo_rd     = state_q inside {S_HDR, S_BODY, S_LAST};
  assign sts_rd      = state_q inside {S_BC, S_POLL, S_BBC, S_MID, S_FIN};
  assign txn_addr_o  = ADDR_W'((state_q == S_WR || fifo_rd) ? FIFO_ADDR : STS_ADDR);

  always_comb begin
    case (state_q)
      S_WR, S_BODY: txn_len_o = chunk_q;
      S_HDR:        txn_len_o = LW'(HDR_BYTES);
      S_LAST:       txn_len_o = LW'(1);
      default:      txn_len_o = LW'(4);
    endcase
  end

  always_comb begin
    txn_wdata_o = 8'h00;
    case (state_q)
      S_WR:         txn_wdata_o = cmd_data_i;
      S_RDY, S_REL: if (idx_q == '0) txn_wdata_o = STS_CMD_READY;
      S_GO:         if (idx_q == '0) txn_wdata_o = STS_GO;
      default:      txn_wdata_o = 8'h00;
    endcase
  end

  assign cmd_addr_o = (state_q == S_LEN) ? BUF_AW'(idx_q) + BUF_AW'(2) : cmd_ptr_q[BUF_AW-1:0];
  assign rsp_we_o   = txn_rvalid_i && fifo_rd;
  assign rsp_addr_o = rsp_ptr_q[BUF_AW-1:0];
  assign rsp_data_o = txn_rdata_i;

  // chunk size for command writes or response body reads
  assign remain = (state_q == S_BC) ? cmd_len_q - cmd_ptr_q : rsp_len_q - BL'(1) - rsp_ptr_q;

  tpm_fifo_seq_chunk #(.RW(BL), .MAX_CHUNK(MAX_CHUNK), .LW(LW)) u_chunk (
    .remain_i (remain),
    .burst_i  (burst_now),
    .len_o    (chunk_len)
  );

  tpm_fifo_seq_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state_q == S_GO && txn_done_i),
    .wait_i     (state_q == S_WAIT),
    .active_i   (state_q == S_WAIT || state_q == S_POLL),
    .poll_due_o (poll_due),
    .expired_o  (expired)
  );

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_err = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_LEN;
      S_LEN:  if (idx_q == LW'(3)) state_d = S_CMP;
      S_CMP:  if (len_ok) state_d = S_RDY; else begin fin = 1'b1; fin_err = 1'b1; end
      S_RDY:  if (txn_done_i) state_d = S_BC;
      S_BC:   if (txn_done_i && burst_now != '0) state_d = S_WR;
      S_WR:   if (txn_done_i) state_d = (cmd_ptr_q == cmd_len_q) ? S_GO : S_BC;
      S_GO:   if (txn_done_i) state_d = S_WAIT;
      S_WAIT: if (expired) begin fin = 1'b1; fin_err = 1'b1; end
              else if (poll_due) state_d = S_POLL;
      S_POLL: if (txn_done_i) state_d = avail_both ? S_HDR : S_WAIT;
      S_HDR:  if (txn_done_i) state_d = S_HCHK;
      S_HCHK: if (field_q > 32'(rsp_max_q) || field_q < 32'd7) begin
                fin = 1'b1; fin_err = 1'b1;
              end else state_d = (field_q == 32'd7) ? S_MID : S_BBC;
      S_BBC:  if (txn_done_i && burst_now != '0) state_d = S_BODY;
      S_BODY: if (txn_done_i) state_d = (rsp_ptr_q == rsp_len_q - BL'(1)) ? S_MID : S_BBC;
      S_MID:  if (txn_done_i) begin
                if (avail_both) state_d = S_LAST; else begin fin = 1'b1; fin_err = 1'b1; end
              end
      S_LAST: if (txn_done_i) state_d = S_FIN;
      S_FIN:  if (txn_done_i) begin
                if ((sts_q[7:0] & AVAIL_MASK) == STS_VALID) state_d = S_REL;
                else begin fin = 1'b1; fin_err = 1'b1; end
              end
      S_REL:  if (txn_done_i) fin = 1'b1;
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      sts_q     <= '0;
      field_q   <= '0;
      cmd_len_q <= '0;
      rsp_max_q <= '0;
      cmd_ptr_q <= '0;
      rsp_ptr_q <= '0;
      rsp_len_q <= '0;
      rsp_out_q <= '0;
      burst_q   <= '0;
      chunk_q   <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (fin) begin
        err_q     <= fin_err;
        rsp_out_q <= fin_err ? '0 : rsp_len_q;
      end
      if (state_q == S_IDLE && start_i) begin
        cmd_len_q <= cmd_len_i;
        rsp_max_q <= rsp_max_i;
        cmd_ptr_q <= '0;
        rsp_ptr_q <= '0;
        rsp_len_q <= '0;
        rsp_out_q <= '0;
        err_q     <= 1'b0;
      end
      // byte index within the current transaction
      if (state_q == S_LEN) idx_q <= idx_q + LW'(1);
      else if (txn_req_o) begin
        if (txn_done_i) idx_q <= '0;
        else if (txn_wtake_i || txn_rvalid_i) idx_q <= idx_q + LW'(1);
      end else idx_q <= '0;
      if (sts_rd && txn_rvalid_i) begin
        case (idx_q)
          LW'(0): sts_q[7:0]   <= txn_rdata_i;
          LW'(1): sts_q[15:8]  <= txn_rdata_i;
          LW'(2): sts_q[23:16] <= txn_rdata_i;
          default: ;
        endcase
      end
      if (state_q == S_LEN) field_q <= {field_q[23:0], cmd_data_i};
      if (state_q == S_HDR && txn_rvalid_i && idx_q >= LW'(2) && idx_q <= LW'(5))
        field_q <= {field_q[23:0], txn_rdata_i};
      if (state_q == S_WR && txn_wtake_i) cmd_ptr_q <= cmd_ptr_q + BL'(1);
      if (rsp_we_o) rsp_ptr_q <= rsp_ptr_q + BL'(1);
      if ((state_q == S_BC || state_q == S_BBC) && txn_done_i && burst_now != '0) begin
        burst_q <= burst_now;
        chunk_q <= chunk_len;
      end
      if (state_q == S_HCHK) rsp_len_q <= BL'(field_q);
    end
  end

  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rsp_len_o = rsp_out_q;

  p_len_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_req_o |-> (txn_len_o != '0 && 32'(txn_len_o) <= 32'(MAX_CHUNK)));
  p_chunk_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR || state_q == S_BODY) |-> 16'(txn_len_o) <= burst_q);
  p_cmd_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR && txn_wtake_i) |-> cmd_ptr_q < cmd_len_q);
  p_go_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_GO) |-> cmd_ptr_q == cmd_len_q);
  p_rsp_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_we_o && state_q != S_HDR) |-> rsp_ptr_q < rsp_len_q);
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_len_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> rsp_len_o == '0);
endmodule

// File: tb/tpm_fifo_seq_bench.sv
`timescale 1ns/1ps
module tpm_fifo_seq_bench;
  localparam int STS  = 24'h18;
  localparam int FIFO = 24'h24;
  localparam int POLL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start_i = 1'b0;
  logic [12:0] cmd_len_i = '0, rsp_max_i = '0;
  logic [11:0] cmd_addr_o, rsp_addr_o;
  logic [7:0]  cmd_data_i, rsp_data_o, txn_wdata_o, txn_rdata_i;
  logic        rsp_we_o, txn_req_o, txn_write_o, done_o, err_o;
  logic [23:0] txn_addr_o;
  logic [6:0]  txn_len_o;
  logic        txn_wtake_i, txn_rvalid_i, txn_done_i;
  logic [12:0] rsp_len_o;

  logic [7:0] cmd_mem [256];
  logic [7:0] rsp_mem [256];
  logic [7:0] rsp_src [256];
  logic [7:0] got_cmd [256];
  int got_n, dev_rd_ptr, rsp_total, burst_val, zero_left, poll_left;
  bit go_seen, drop_mid, keep_final;
  int log_n, cyc;
  bit log_w [128];
  int log_a [128], log_l [128], log_t [128];
  logic [7:0] log_d0 [128];
  int n_chk, n_fail;

  assign cmd_data_i = cmd_mem[cmd_addr_o[7:0]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_we_o) rsp_mem[rsp_addr_o[7:0]] <= rsp_data_o;
  end

  tpm_fifo_seq #(.POLL_CYC(POLL), .TIMEOUT_CYC(64'd200)) u_tpm_fifo_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .cmd_len_i(cmd_len_i),
    .cmd_addr_o(cmd_addr_o), .cmd_data_i(cmd_data_i), .rsp_max_i(rsp_max_i),
    .rsp_we_o(rsp_we_o), .rsp_addr_o(rsp_addr_o), .rsp_data_o(rsp_data_o),
    .txn_req_o(txn_req_o), .txn_write_o(txn_write_o), .txn_addr_o(txn_addr_o),
    .txn_len_o(txn_len_o), .txn_wdata_o(txn_wdata_o), .txn_wtake_i(txn_wtake_i),
    .txn_rvalid_i(txn_rvalid_i), .txn_rdata_i(txn_rdata_i), .txn_done_i(txn_done_i),
    .done_o(done_o), .err_o(err_o), .rsp_len_o(rsp_len_o)
  );

  function automatic logic [31:0] dev_status();
    logic [15:0] b;
    logic [7:0]  lo;
    bit da;
    if (zero_left > 0) begin b = 16'h0; zero_left--; end
    else b = 16'(burst_val);
    lo = 8'h80;
    if (!go_seen) lo = lo | 8'h40;
    else if (poll_left > 0) poll_left--;
    else begin
      da = dev_rd_ptr < rsp_total;
      if (drop_mid && dev_rd_ptr == rsp_total - 1) da = 1'b0;
      if (keep_final && dev_rd_ptr == rsp_total) da = 1'b1;
      if (da) lo = lo | 8'h10;
    end
    return {8'h00, b, lo};
  endfunction

  // register transaction master plus device model
  initial begin
    bit w;
    int a, l;
    logic [31:0] sw;
    logic [7:0] d, d0;
    txn_wtake_i = 0; txn_rvalid_i = 0; txn_rdata_i = 0; txn_done_i = 0;
    forever begin
      @(negedge clk);
      if (txn_req_o) begin
        w = txn_write_o; a = int'(txn_addr_o); l = int'(txn_len_o); d0 = 8'h00;
        sw = '0;
        if (!w && a == STS) sw = dev_status();
        for (int i = 0; i < l; i++) begin
          if (w) begin
            d = txn_wdata_o;
            if (i == 0) d0 = d;
            if (a == FIFO) begin got_cmd[got_n[7:0]] = d; got_n++; end
            txn_wtake_i = 1; @(negedge clk); txn_wtake_i = 0;
          end else begin
            if (a == STS) txn_rdata_i = sw[8*(i%4) +: 8];
            else begin txn_rdata_i = rsp_src[dev_rd_ptr[7:0]]; dev_rd_ptr++; end
            txn_rvalid_i = 1; @(negedge clk); txn_rvalid_i = 0;
          end
        end
        if (w && a == STS) begin
          if (d0 == 8'h20) go_seen = 1;
          else if (d0 == 8'h40) go_seen = 0;
        end
        if (log_n < 128) begin
          log_w[log_n] = w; log_a[log_n] = a; log_l[log_n] = l;
          log_d0[log_n] = d0; log_t[log_n] = cyc; log_n++;
        end
        txn_done_i = 1; @(negedge clk); txn_done_i = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int nth(bit w, int a, int k);
    int c = 0;
    for (int i = 0; i < log_n; i++)
      if (log_w[i] == w && log_a[i] == a) begin
        if (c == k) return i;
        c++;
      end
    return -1;
  endfunction

  function automatic int cnt(bit w, int a);
    int c = 0;
    for (int i = 0; i < log_n; i++) if (log_w[i] == w && log_a[i] == a) c++;
    return c;
  endfunction

  function automatic int len_of(int i);
    return (i < 0) ? -1 : log_l[i];
  endfunction

  task automatic setup(int clen, int cfield, int burst, int zeros, int polls,
                       int rfield, int rmax);
    for (int i = 0; i < 256; i++) begin
      cmd_mem[i] = 8'(i * 7 + 3);
      rsp_src[i] = 8'(i) ^ 8'h5a;
      rsp_mem[i] = 8'h00;
      got_cmd[i] = 8'h00;
    end
    cmd_mem[0] = 8'h80; cmd_mem[1] = 8'h01;
    {cmd_mem[2], cmd_mem[3], cmd_mem[4], cmd_mem[5]} = 32'(cfield);
    {rsp_src[2], rsp_src[3], rsp_src[4], rsp_src[5]} = 32'(rfield);
    cmd_len_i = 13'(clen); rsp_max_i = 13'(rmax);
    burst_val = burst; zero_left = zeros; poll_left = polls;
    rsp_total = rfield; dev_rd_ptr = 0; got_n = 0; log_n = 0;
    go_seen = 0; drop_mid = 0; keep_final = 0;
  endtask

  task automatic run_seq(output int lat);
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
    lat = 0;
    while (!done_o && lat < 20000) begin @(negedge clk); lat++; end
    check("R11 done seen", int'(done_o), 1);
    @(negedge clk);
    check("R11 done one cycle", int'(done_o), 0);
  endtask

  task automatic t_reset;
    check("R11 reset done", int'(done_o), 0);
    check("R11 reset err", int'(err_o), 0);
    check("R11 reset req", int'(txn_req_o), 0);
    check("R11 reset len", int'(rsp_len_o), 0);
  endtask

  task automatic t_basic;
    int lat, g, h, polls, mingap, lastp, bad;
    setup(20, 20, 8, 0, 3, 23, 64);
    run_seq(lat);
    check("R2 first is write", int'(log_w[0]), 1);
    check("R2 first addr", log_a[0], STS);
    check("R2 first len", log_l[0], 4);
    check("R2 first byte", int'(log_d0[0]), 8'h40);
    check("R4 write count", cnt(1, FIFO), 3);
    check("R4 chunk0", len_of(nth(1, FIFO, 0)), 8);
    check("R4 chunk1", len_of(nth(1, FIFO, 1)), 8);
    check("R4 chunk2", len_of(nth(1, FIFO, 2)), 4);
    bad = 0;
    for (int i = 0; i < 20; i++) if (got_cmd[i] !== cmd_mem[i]) bad++;
    check("R4 command bytes", bad + (got_n == 20 ? 0 : 100), 0);
    g = nth(1, FIFO, 2) + 1;
    check("R5 go addr", log_a[g], STS);
    check("R5 go byte", int'(log_d0[g]) + (log_w[g] ? 0 : 1000), 8'h20);
    h = nth(0, FIFO, 0);
    polls = 0; mingap = 1000; lastp = -1;
    for (int i = g + 1; i < h; i++)
      if (!log_w[i] && log_a[i] == STS) begin
        polls++;
        if (lastp >= 0 && log_t[i] - lastp < mingap) mingap = log_t[i] - lastp;
        lastp = log_t[i];
      end
    check("R6 poll count", polls, 4);
    check("R6 poll spacing", int'(mingap > POLL), 1);
    check("R7 header len", len_of(h), 6);
    check("R8 body chunk0", len_of(nth(0, FIFO, 1)), 8);
    check("R8 body chunk1", len_of(nth(0, FIFO, 2)), 8);
    g = nth(0, FIFO, 2) + 1;
    check("R8 mid status read", int'(!log_w[g] && log_a[g] == STS), 1);
    check("R9 last byte len", len_of(nth(0, FIFO, 3)), 1);
    g = nth(0, FIFO, 3) + 1;
    check("R9 final status read", int'(!log_w[g] && log_a[g] == STS), 1);
    check("R10 release write", int'(log_w[log_n-1] && log_a[log_n-1] == STS
                                    && log_d0[log_n-1] == 8'h40), 1);
    check("R10 no error", int'(err_o), 0);
    check("R10 length", int'(rsp_len_o), 23);
    bad = 0;
    for (int i = 0; i < 23; i++) if (rsp_mem[i] !== rsp_src[i]) bad++;
    check("R10 response bytes", bad, 0);
  endtask

  task automatic t_big_burst;
    int lat, sr;
    setup(70, 70, 100, 2, 0, 7, 64);
    run_seq(lat);
    sr = 0;
    for (int i = 1; i < nth(1, FIFO, 0); i++) if (!log_w[i] && log_a[i] == STS) sr++;
    check("R3 zero burst rereads", sr, 3);
    check("R4 cap 64 chunk0", len_of(nth(1, FIFO, 0)), 64);
    check("R4 cap 64 chunk1", len_of(nth(1, FIFO, 1)), 6);
    check("R8 no body for 7", cnt(0, FIFO), 2);
    check("R10 len 7 ok", int'(rsp_len_o) + (err_o ? 1000 : 0), 7);
  endtask

  task automatic t_mismatch;
    int lat;
    setup(20, 21, 8, 0, 0, 23, 64);
    run_seq(lat);
    check("R1 latency", lat, 5);
    check("R1 no bus traffic", log_n, 0);
    check("R1 error", int'(err_o), 1);
    check("R11 err length zero", int'(rsp_len_o), 0);
    setup(4, 4, 8, 0, 0, 23, 64);
    run_seq(lat);
    check("R1 short command error", int'(err_o) + log_n, 1);
  endtask

  task automatic t_timeout;
    int lat;
    setup(10, 10, 16, 0, 100000, 23, 64);
    run_seq(lat);
    check("R6 timeout error", int'(err_o), 1);
    check("R6 no fifo read", cnt(0, FIFO), 0);
    check("R6 several polls", int'(cnt(0, STS) > 3), 1);
  endtask

  task automatic t_rsp_limits;
    int lat;
    setup(10, 10, 16, 0, 0, 100, 40);
    run_seq(lat);
    check("R7 too long error", int'(err_o), 1);
    check("R7 header is last", int'(!log_w[log_n-1] && log_a[log_n-1] == FIFO
                                     && log_l[log_n-1] == 6), 1);
    setup(10, 10, 16, 0, 0, 6, 40);
    run_seq(lat);
    check("R7 too short error", int'(err_o), 1);
    check("R7 short header only", cnt(0, FIFO), 1);
  endtask

  task automatic t_bad_status;
    int lat;
    setup(20, 20, 8, 0, 0, 23, 64);
    drop_mid = 1;
    run_seq(lat);
    check("R8 mid status error", int'(err_o), 1);
    check("R8 no last byte read", cnt(0, FIFO), 3);
    setup(20, 20, 8, 0, 0, 23, 64);
    keep_final = 1;
    run_seq(lat);
    check("R9 final status error", int'(err_o), 1);
    check("R9 no release write", int'(log_w[log_n-1]), 0);
    check("R11 len zero on error", int'(rsp_len_o), 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_big_burst();
    t_mismatch();
    t_timeout();
    t_rsp_limits();
    t_bad_status();
    summary();
    $finish;
  end
endmodule